// File: doc/BRIEF.md
# Eight-Channel ADC Capture Sequencer

This block drives a parallel-output, simultaneous-sampling analog-to-digital converter through one full capture cycle and keeps the eight results in a small local register file. A change in the sampled level of a push button, in either direction, produces a single-cycle trigger pulse. The trigger starts one acquisition: a conversion-start pulse, a fixed hold wait, a wait for the converter's busy line to drop, and then eight strobe pulses. All eight channels are read every time, including channels that nothing downstream uses.

The datapath holds two counter/comparator timers. The short timer sets the width of the conversion-start pulse and the low and high phases of each read strobe. The long timer sets the hold wait. Each timer's equality output is a status input to the control FSM. Results go into an 8-entry by 16-bit register file with independent write and read ports. The read port is a plain multiplexer that is steered by a read address. Entry 0, which holds channel 1, also feeds four signed comparators. These raise a flag when the stored word reaches the code for 1, 2, 3 or 4 volts.

The control FSM has seven states. IDLE goes to CONVERT on a trigger. CONVERT goes to HOLD when the short timer hits. HOLD goes to DRAIN when the long timer hits. DRAIN goes to STROBE_LO once busy is low. STROBE_LO goes to STROBE_HI when the short timer hits, and the word is written on that edge. STROBE_HI goes back to STROBE_LO when the short timer hits and the channel is not the last one. STROBE_HI goes to FINISH when the short timer hits on the last channel. FINISH always returns to IDLE. Next-state logic and output decode are separate processes. The outputs form a control word for the datapath.

Top module: `adc_acq_seq`

## Requirements
- R1: When the registered button level differs from its previous registered value, `adc_convst` goes high at the second rising edge after the button input changes, provided the sequencer is in IDLE. A steady button level never starts an acquisition.
- R2: `adc_convst` stays high for exactly SHORT_TERM+1 clock cycles for each acquisition.
- R3: After `adc_convst` falls, the first strobe does not begin for at least LONG_TERM+2 cycles. It then begins on the cycle after `adc_busy` is sampled low.
- R4: Each acquisition makes exactly eight strobe pulses. In each pulse, `adc_cs_n` and `adc_rd_n` are low together for SHORT_TERM+1 cycles, then high together for SHORT_TERM+1 cycles. No strobe is low while `adc_convst` is high.
- R5: On the k-th strobe (k = 0..7), the value present on `adc_data` on the last low cycle is stored in register-file entry k.
- R6: `rd_data` always shows the entry selected by `rd_addr`, combinationally, independent of the sequencer's state.
- R7: `acq_done` is high for exactly one cycle, on the cycle after the eighth strobe's high phase ends. The sequencer is idle on the next cycle.
- R8: A button change that arrives while an acquisition is in progress does not start a further acquisition.
- R9: A synchronous reset puts the sequencer in IDLE, with `adc_convst`=0, `adc_cs_n`=1, `adc_rd_n`=1 and `acq_done`=0 on the cycle after the reset edge, and clears both timers. Register-file contents are not reset.
- R10: `lvl_flag[k]` (bit k, k = 0..3) is 1 exactly when entry 0, read as signed 16-bit, is greater than or equal to (k+1)*VOLT_CODE. Bit 0 is the 1-volt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_in | input | 1 | Button level; any change triggers an acquisition |
| adc_busy | input | 1 | Converter busy, high while converting |
| adc_data | input | DATA_W | Converter parallel output |
| rd_addr | input | CH_W | Register-file read index |
| adc_convst | output | 1 | Conversion start, active high |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| rd_data | output | DATA_W | Selected register-file entry |
| acq_done | output | 1 | One-cycle completion pulse |
| lvl_flag | output | NUM_LVL | Channel 1 threshold flags |

## Verification
The bench builds the block with SHORT_TERM = 2 and LONG_TERM = 40 in place of the default hold of 0x00FFFF, so that a full acquisition takes about a hundred cycles and many acquisitions fit in one run. At these values the bench's converter model can hold busy either for a short time inside the hold window or for longer than the hold. This exercises both the immediate exit from DRAIN and the case where DRAIN has to wait. Each run places channel-1 samples below, exactly at, and above the threshold codes, including negative codes, so that every flag boundary is crossed.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_HOLD,
        ST_DRAIN,
        ST_STROBE_LO,
        ST_STROBE_HI,
        ST_FINISH
    } acq_state_e;

    // control word from the FSM to the datapath
    typedef struct packed {
        logic convst;
        logic strobe_n;
        logic short_run;
        logic long_run;
        logic wr_en;
        logic ch_step;
        logic done;
    } acq_ctrl_t;

endpackage

// File: rtl/acq_edge_trig.sv
module acq_edge_trig (
    input  logic clk,
    input  logic rst,
    input  logic lvl_in,
    output logic pulse
);
    logic samp_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            samp_q <= lvl_in;
            prev_q <= lvl_in;
        end else begin
            samp_q <= lvl_in;
            prev_q <= samp_q;
        end
    end

    assign pulse = samp_q ^ prev_q;
endmodule

// File: rtl/acq_delay_timer.sv
module acq_delay_timer #(
    parameter int          CNT_W = 4,
    parameter int unsigned TERM  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam logic [CNT_W-1:0] TERM_C = CNT_W'(TERM);

    logic [CNT_W-1:0] cnt_q;

    assign hit = (cnt_q == TERM_C);

    always_ff @(posedge clk) begin
        if (rst || !run || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/acq_regfile.sv
module acq_regfile #(
    parameter int NUM_CH = 8,
    parameter int DATA_W = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [CH_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CH_W-1:0]   raddr,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] word0
);
    logic [DATA_W-1:0] words [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ent
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (we && (waddr == CH_W'(i))) begin
                word_q <= wdata;
            end
        end
        assign words[i] = word_q;
    end

    assign rdata = words[raddr];
    assign word0 = words[0];
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
    import adc_acq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trig,
    input  logic       busy,
    input  logic       short_hit,
    input  logic       long_hit,
    input  logic       last_ch,
    output acq_state_e state,
    output acq_ctrl_t  ctrl
);
    acq_state_e state_q;
    acq_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (trig)      state_d = ST_CONVERT;
            ST_CONVERT:   if (short_hit) state_d = ST_HOLD;
            ST_HOLD:      if (long_hit)  state_d = ST_DRAIN;
            ST_DRAIN:     if (!busy)     state_d = ST_STROBE_LO;
            ST_STROBE_LO: if (short_hit) state_d = ST_STROBE_HI;
            ST_STROBE_HI: if (short_hit) state_d = last_ch ? ST_FINISH : ST_STROBE_LO;
            ST_FINISH:                   state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl = '0;
        ctrl.strobe_n = 1'b1;
        unique case (state_q)
            ST_IDLE: ;
            ST_CONVERT: begin
                ctrl.convst    = 1'b1;
                ctrl.short_run = 1'b1;
            end
            ST_HOLD: ctrl.long_run = 1'b1;
            ST_DRAIN: ;
            ST_STROBE_LO: begin
                ctrl.strobe_n  = 1'b0;
                ctrl.short_run = 1'b1;
                ctrl.wr_en     = short_hit;
            end
            ST_STROBE_HI: begin
                ctrl.short_run = 1'b1;
                ctrl.ch_step   = short_hit;
            end
            ST_FINISH: ctrl.done = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/acq_datapath.sv
module acq_datapath
    import adc_acq_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter int          DATA_W     = 16,
    parameter int          SHORT_W    = 4,
    parameter int unsigned SHORT_TERM = 2,
    parameter int          LONG_W     = 24,
    parameter int unsigned LONG_TERM  = 32'h00FFFF,
    parameter int          NUM_LVL    = 4,
    parameter int          VOLT_CODE  = 3277,
    localparam int         CH_W       = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  acq_ctrl_t          ctrl,
    input  logic [DATA_W-1:0]  adc_data,
    input  logic [CH_W-1:0]    rd_addr,
    output logic               short_hit,
    output logic               long_hit,
    output logic               last_ch,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_LVL-1:0] lvl_flag
);
    logic [CH_W-1:0]   ch_q;
    logic [DATA_W-1:0] word0;

    acq_delay_timer #(.CNT_W(SHORT_W), .TERM(SHORT_TERM)) u_short (
        .clk (clk),
        .rst (rst),
        .run (ctrl.short_run),
        .hit (short_hit)
    );

    acq_delay_timer #(.CNT_W(LONG_W), .TERM(LONG_TERM)) u_long (
        .clk (clk),
        .rst (rst),
        .run (ctrl.long_run),
        .hit (long_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q <= '0;
        end else if (ctrl.ch_step) begin
            ch_q <= last_ch ? '0 : ch_q + 1'b1;
        end
    end

    assign last_ch = (ch_q == CH_W'(NUM_CH - 1));

    acq_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_rf (
        .clk   (clk),
        .we    (ctrl.wr_en),
        .waddr (ch_q),
        .wdata (adc_data),
        .raddr (rd_addr),
        .rdata (rd_data),
        .word0 (word0)
    );

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
        localparam logic signed [DATA_W-1:0] THR = DATA_W'((k + 1) * VOLT_CODE);
        assign lvl_flag[k] = ($signed(word0) >= THR);
    end
endmodule

// File: rtl/adc_acq_seq.sv
module adc_acq_seq
    import adc_acq_pkg::*;
#(
    parameter int          NUM_CH     = 8,
    parameter int          DATA_W     = 16,
    parameter int          SHORT_W    = 4,
    parameter int unsigned SHORT_TERM = 2,
    parameter int          LONG_W     = 24,
    parameter int unsigned LONG_TERM  = 32'h00FFFF,
    parameter int          NUM_LVL    = 4,
    parameter int          VOLT_CODE  = 3277,
    localparam int         CH_W       = $clog2(NUM_CH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               btn_in,
    input  logic               adc_busy,
    input  logic [DATA_W-1:0]  adc_data,
    input  logic [CH_W-1:0]    rd_addr,
    output logic               adc_convst,
    output logic               adc_cs_n,
    output logic               adc_rd_n,
    output logic [DATA_W-1:0]  rd_data,
    output logic               acq_done,
    output logic [NUM_LVL-1:0] lvl_flag
);
    logic       trig;
    logic       short_hit;
    logic       long_hit;
    logic       last_ch;
    acq_state_e state_q;
    acq_ctrl_t  ctrl;

    acq_edge_trig u_trig (
        .clk    (clk),
        .rst    (rst),
        .lvl_in (btn_in),
        .pulse  (trig)
    );

    acq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .busy      (adc_busy),
        .short_hit (short_hit),
        .long_hit  (long_hit),
        .last_ch   (last_ch),
        .state     (state_q),
        .ctrl      (ctrl)
    );

    acq_datapath #(
        .NUM_CH     (NUM_CH),
        .DATA_W     (DATA_W),
        .SHORT_W    (SHORT_W),
        .SHORT_TERM (SHORT_TERM),
        .LONG_W     (LONG_W),
        .LONG_TERM  (LONG_TERM),
        .NUM_LVL    (NUM_LVL),
        .VOLT_CODE  (VOLT_CODE)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .adc_data  (adc_data),
        .rd_addr   (rd_addr),
        .short_hit (short_hit),
        .long_hit  (long_hit),
        .last_ch   (last_ch),
        .rd_data   (rd_data),
        .lvl_flag  (lvl_flag)
    );

    assign adc_convst = ctrl.convst;
    assign adc_cs_n   = ctrl.strobe_n;
    assign adc_rd_n   = ctrl.strobe_n;
    assign acq_done   = ctrl.done;
endmodule

// File: rtl/adc_acq_seq_chk.sv
module adc_acq_seq_chk
    import adc_acq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       convst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       done,
    input logic       trig,
    input logic       we,
    input acq_state_e st
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!convst && cs_n && rd_n && !done)); // R9

    AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && trig) |=> convst); // R1

    AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE && st != ST_CONVERT && trig) |=> !convst); // R8

    AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (rst)
        cs_n == rd_n); // R4

    AST_NO_STROBE_IN_CONV: assert property (@(posedge clk) disable iff (rst)
        !(convst && !rd_n)); // R4

    AST_WRITE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        we |-> !rd_n); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && st == ST_IDLE)); // R7
endmodule

bind adc_acq_seq adc_acq_seq_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .convst (adc_convst),
    .cs_n   (adc_cs_n),
    .rd_n   (adc_rd_n),
    .done   (acq_done),
    .trig   (trig),
    .we     (ctrl.wr_en),
    .st     (state_q)
);

// File: tb/adc_acq_seq_test.sv
module adc_acq_seq_test;
    localparam int NCH  = 8;
    localparam int DW   = 16;
    localparam int S    = 2;
    localparam int L    = 40;
    localparam int VC   = 3277;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn = 1'b0;
    logic adc_busy = 1'b0;
    logic [DW-1:0] adc_data = '0;
    logic [2:0] rd_addr = '0;
    logic adc_convst, adc_cs_n, adc_rd_n, acq_done;
    logic [DW-1:0] rd_data;
    logic [3:0] lvl_flag;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    adc_acq_seq #(.SHORT_TERM(S), .LONG_TERM(L)) uut (
        .clk(clk), .rst(rst), .btn_in(btn), .adc_busy(adc_busy),
        .adc_data(adc_data), .rd_addr(rd_addr), .adc_convst(adc_convst),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .rd_data(rd_data),
        .acq_done(acq_done), .lvl_flag(lvl_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- converter model ----------------
    logic [DW-1:0] samp [NCH];
    int blen = 10;
    int bt = 0;
    bit bact = 0;
    int idx = 0;
    logic cv_q = 0, rd_q = 1;

    always @(negedge clk) begin
        if (adc_convst && !cv_q) begin
            bt = 0; bact = 1; idx = 0;
        end else if (bact) begin
            bt++;
        end
        adc_busy = bact && (bt >= 2) && (bt < 2 + blen);
        if (!rd_q && adc_rd_n) idx++;
        cv_q = adc_convst;
        rd_q = adc_rd_n;
        adc_data = samp[idx % NCH];
    end

    // ---------------- behavioural reference ----------------
    int ph = 0;   // 0 idle 1 conv 2 hold 3 drain 4 low 5 high 6 finish
    int sc = 0, lc = 0, ch = 0;
    logic m_s0 = 0, m_s1 = 0;
    logic [DW-1:0] m_mem [NCH];
    bit m_valid [NCH];

    initial for (int i = 0; i < NCH; i++) m_valid[i] = 0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; sc = 0; lc = 0; ch = 0;
            m_s0 = btn; m_s1 = btn;
        end else begin
            bit t;
            int nph;
            t = m_s0 ^ m_s1;
            m_s1 = m_s0; m_s0 = btn;
            nph = ph;
            case (ph)
                0: if (t) nph = 1;
                1: if (sc == S) nph = 2;
                2: if (lc == L) nph = 3;
                3: if (!adc_busy) nph = 4;
                4: if (sc == S) begin
                       m_mem[ch] = adc_data; m_valid[ch] = 1; nph = 5;
                   end
                5: if (sc == S) begin
                       nph = (ch == NCH - 1) ? 6 : 4;
                       ch = (ch + 1) % NCH;
                   end
                default: nph = 0;
            endcase
            if ((ph == 1 || ph == 4 || ph == 5) && sc != S) sc++; else sc = 0;
            if (ph == 2 && lc != L) lc++; else lc = 0;
            ph = nph;
        end
    end

    function automatic logic [3:0] exp_flags(input logic [DW-1:0] w);
        logic [3:0] f;
        for (int k = 0; k < 4; k++) f[k] = ($signed(w) >= $signed(DW'((k + 1) * VC)));
        return f;
    endfunction

    always @(posedge clk) begin
        #3;
        chk("R1 R2 convst", adc_convst, (ph == 1));
        chk("R3 R4 cs_n", adc_cs_n, !(ph == 4));
        chk("R4 rd_n", adc_rd_n, !(ph == 4));
        chk("R7 done", acq_done, (ph == 6));
        if (m_valid[rd_addr]) chk("R6 rd_data", rd_data, m_mem[rd_addr]);
        if (m_valid[0]) chk("R10 flags", lvl_flag, exp_flags(m_mem[0]));
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // ---------------- directed acquisition ----------------
    task automatic run_acq(input logic [DW-1:0] ch0, input int busy_len, input bit late_tog);
        int strobes = 0, dones = 0, n = 0, gap = -1, cvfall = -1, convw = 0;
        bit prev_rd = 1, prev_cv = 0, seen_rd = 0;
        for (int i = 0; i < NCH; i++) samp[i] = DW'(16'h1111 * (i + 1) + cyc);
        samp[0] = ch0;
        blen = busy_len;
        @(negedge clk);
        btn = ~btn;
        while (dones == 0 && n < 2000) begin
            @(negedge clk);
            n++;
            if (late_tog && n == 30) btn = ~btn; // R8: change during acquisition
            if (adc_convst) convw++;
            if (prev_cv && !adc_convst) cvfall = n;
            if (!adc_rd_n && !seen_rd) begin seen_rd = 1; gap = n - cvfall; end
            if (prev_rd && !adc_rd_n) strobes++;
            if (acq_done) dones++;
            prev_rd = adc_rd_n; prev_cv = adc_convst;
        end
        chk("R2 convst width", convw, S + 1);
        tests++;
        if (gap < L + 2) begin
            fails++;
            $display("FAIL R3 hold gap actual=%0d expected>=%0d", gap, L + 2);
        end
        chk("R4 strobe count", strobes, NCH);
        chk("R7 done seen", dones, 1);
        // nothing further may start (R8)
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (adc_convst) dones++;
        end
        chk("R8 no restart", dones, 1);
        for (int a = 0; a < NCH; a++) begin
            rd_addr = 3'(a);
            @(negedge clk);
            chk("R5 R6 stored word", rd_data, samp[a]);
        end
        chk("R10 flags", lvl_flag, exp_flags(ch0));
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) samp[i] = '0;
        repeat (3) @(negedge clk);
        chk("R9 reset convst", adc_convst, 0);
        chk("R9 reset cs_n", adc_cs_n, 1);
        chk("R9 reset done", acq_done, 0);
        rst = 1'b0;
        repeat (20) @(negedge clk);
        chk("R1 no start on steady level", adc_convst, 0);
        // R1 timing: convst high at second edge after change
        @(negedge clk); btn = ~btn;
        @(negedge clk);
        chk("R1 not yet", adc_convst, 0);
        @(negedge clk);
        chk("R1 convst rises", adc_convst, 1);
        repeat (300) @(negedge clk);
        run_acq(16'h0000, 10, 0);
        run_acq(16'(VC), 10, 0);
        run_acq(16'(VC - 1), 80, 0);
        run_acq(16'(2 * VC + 100), 10, 1);
        run_acq(16'(4 * VC), 80, 0);
        run_acq(16'hEC78, 10, 1);
        run_acq(16'h7FFF, 5, 0);
        // mid-run reset
        @(negedge clk); btn = ~btn;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset mid-run convst", adc_convst, 0);
        chk("R9 reset mid-run rd_n", adc_rd_n, 1);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule